// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block gathers eight asynchronous external pins into a single interrupt request. Each pin first passes through a synchronizer. A per-channel filter then advances only on a one-millisecond tick pulse, so a pin is accepted as a new stable level only after it has held that level for a programmed number of ticks. The filtered level of every channel is visible to software. The filtered level is compared with a per-channel polarity bit, and a match sets a sticky raw status bit. A raw status bit reaches the shared interrupt output only when both the channel's enable bit and its arm bit are set. Interrupts are level-sensitive only. Software emulates edge detection by reading the filtered level and then flipping the polarity bit.

Software uses a simple synchronous register port. A write is taken on any clock edge where `reg_we` is high. A read returns data combinationally for the address on `reg_addr`. Each channel has a gate bit. While a channel's gate bit is clear, its filter is held in reset and its level reads 0.

Each filter is a three-state machine:
- `F_OFF`: held, level 0. It moves to `F_STABLE` once the gate bit is 1.
- `F_STABLE`: moves to `F_QUAL` when the synchronized input differs from the held level.
- `F_QUAL`: counting ticks. It has three exits:
  - back to `F_STABLE` with the count dropped, if the input returns to the held level;
  - to `F_STABLE` with the new level taken, on the tick that completes the count;
  - to `F_OFF` from either `F_STABLE` or `F_QUAL` as soon as the gate bit is 0.

Top module: `dbnc_irq_bank`

## Requirements
- R1: After reset, every register reads 0, with two exceptions: the polarity register reads 0xFF, and `irq` is low.
- R2: The register offsets are as follows.
  - Level (read-only): 0x00.
  - Gate: 0x04.
  - Polarity: 0x14.
  - Enable: 0x18.
  - Raw status: 0x1C.
  - Pending: 0x20.
  - Acknowledge: 0x24.
  - Arm: 0x28.
  - Channel n stable-time register: 0x40+4n. It stores and returns all 32 written bits, but only bits [11:0] set the tick count.
  - In every bitwise register, bit n belongs to channel n.
- R3: While a channel's gate bit is 0, its filter is held in reset, and its level bit reads 0 whatever the pin and tick inputs do.
- R4: A gated channel's level bit takes a new pin value only after the synchronized pin has differed from the current level across N tick pulses. N is bits [11:0] of the channel's stable-time register. After N-1 such pulses the old level still reads.
- R5: A stable-time field of 0 behaves as 1: a single tick pulse is enough.
- R6: If the pin returns to the current level before the N-th tick, the tick count restarts. A later change again needs N fresh ticks.
- R7: When a channel's polarity bit is 1, a filtered level of 1 sets its raw status bit. When the polarity bit is 0, a filtered level of 0 sets it.
- R8: Writing 1 to a bit of the acknowledge register clears that raw status bit, and writing 0 leaves it alone. If the selected level is still present, the bit sets again at once.
- R9: Pending status equals raw AND enable AND arm, bit by bit. `irq` is high exactly when any pending bit is 1.
- R10: Writes to the level, raw status and pending registers have no effect. The acknowledge register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe, taken on the clock edge |
| reg_addr | input | AW (8) | Byte address for read and write |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, combinational |
| pin_in | input | NCH (8) | Asynchronous external pins |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: eight channels, a 12-bit stable-time field and two synchronizer stages. The tick is a bench-driven pulse, so millisecond-scale settings become a handful of cycles. This lets the bench reach several cases directly:
- the exact tick on which a filtered level flips;
- the zero-length setting;
- a bounce that restarts the count;
- upper stable-time bits that must be stored but must not affect the count.

Using all eight channels puts gated and ungated channels side by side. Polarity flipping, acknowledge while the level is still active, and each enable/arm combination are then observed on the pending register and on `irq`.

// File: rtl/dbnc_pkg.sv
`timescale 1ns/1ps
package dbnc_pkg;
    typedef enum logic [1:0] {
        F_OFF    = 2'd0,
        F_STABLE = 2'd1,
        F_QUAL   = 2'd2
    } filt_state_e;

    localparam logic [7:0] OFS_LEVEL = 8'h00;
    localparam logic [7:0] OFS_GATE  = 8'h04;
    localparam logic [7:0] OFS_POL   = 8'h14;
    localparam logic [7:0] OFS_EN    = 8'h18;
    localparam logic [7:0] OFS_RAW   = 8'h1C;
    localparam logic [7:0] OFS_PEND  = 8'h20;
    localparam logic [7:0] OFS_ACK   = 8'h24;
    localparam logic [7:0] OFS_ARM   = 8'h28;
    localparam logic [7:0] OFS_TIME  = 8'h40;
endpackage

// File: rtl/sync_bus.sv
`timescale 1ns/1ps
module sync_bus #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbnc_chan.sv
`timescale 1ns/1ps
module dbnc_chan
    import dbnc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             tick,
    input  logic             din,
    input  logic [CNT_W-1:0] limit,
    output logic             level
);
    filt_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_limit;
    logic             lvl_q;
    logic             done;

    // A zero field still needs one tick.
    assign eff_limit = (limit == '0) ? CNT_W'(1) : limit;
    assign done      = tick && ((cnt_q + CNT_W'(1)) >= eff_limit);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= F_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            F_OFF: begin
                if (gate) st_d = F_STABLE;
            end
            F_STABLE: begin
                if (!gate)              st_d = F_OFF;
                else if (din != lvl_q)  st_d = F_QUAL;
            end
            F_QUAL: begin
                if (!gate)              st_d = F_OFF;
                else if (din == lvl_q)  st_d = F_STABLE;
                else if (done)          st_d = F_STABLE;
            end
            default: st_d = F_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !gate) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                F_OFF: begin
                    cnt_q <= '0;
                end
                F_STABLE: begin
                    cnt_q <= '0;
                end
                F_QUAL: begin
                    if (din == lvl_q) begin
                        cnt_q <= '0;
                    end else if (done) begin
                        lvl_q <= din;
                        cnt_q <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/irq_gather.sv
`timescale 1ns/1ps
module irq_gather #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] level,
    input  logic [NCH-1:0] pol,
    input  logic [NCH-1:0] clr,
    input  logic [NCH-1:0] en,
    input  logic [NCH-1:0] arm,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] pend,
    output logic           irq
);
    logic [NCH-1:0] raw_q;
    logic [NCH-1:0] active;

    assign active = ~(level ^ pol);

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= active | (raw_q & ~clr);
    end

    assign raw  = raw_q;
    assign pend = raw_q & en & arm;
    assign irq  = |pend;
endmodule

// File: rtl/dbnc_irq_bank.sv
`timescale 1ns/1ps
module dbnc_irq_bank
    import dbnc_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int CNT_W       = 12,
    parameter int DW          = 32,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NCH-1:0] pin_in,
    input  logic          tick_ms,
    output logic          irq
);
    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] lvl_vec;
    logic [NCH-1:0] gate_q, pol_q, en_q, arm_q;
    logic [NCH-1:0] raw_vec, pend_vec, clr_vec;
    logic [DW-1:0]  time_q [NCH];
    logic [NCH-1:0] time_hit;

    logic sel_gate, sel_pol, sel_en, sel_arm, sel_ack;
    logic sel_level, sel_raw, sel_pend;

    assign sel_level = (reg_addr == AW'(OFS_LEVEL));
    assign sel_gate  = (reg_addr == AW'(OFS_GATE));
    assign sel_pol   = (reg_addr == AW'(OFS_POL));
    assign sel_en    = (reg_addr == AW'(OFS_EN));
    assign sel_raw   = (reg_addr == AW'(OFS_RAW));
    assign sel_pend  = (reg_addr == AW'(OFS_PEND));
    assign sel_ack   = (reg_addr == AW'(OFS_ACK));
    assign sel_arm   = (reg_addr == AW'(OFS_ARM));

    assign clr_vec = (reg_we && sel_ack) ? reg_wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
            pol_q  <= '1;
            en_q   <= '0;
            arm_q  <= '0;
        end else if (reg_we) begin
            if (sel_gate) gate_q <= reg_wdata[NCH-1:0];
            if (sel_pol)  pol_q  <= reg_wdata[NCH-1:0];
            if (sel_en)   en_q   <= reg_wdata[NCH-1:0];
            if (sel_arm)  arm_q  <= reg_wdata[NCH-1:0];
        end
    end

    sync_bus #(
        .W      (NCH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign time_hit[g] = (reg_addr == AW'(32'(OFS_TIME) + 32'(4 * g)));

        always_ff @(posedge clk) begin
            if (!rst_n)                      time_q[g] <= '0;
            else if (reg_we && time_hit[g])  time_q[g] <= reg_wdata;
        end

        dbnc_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .gate  (gate_q[g]),
            .tick  (tick_ms),
            .din   (pin_s[g]),
            .limit (time_q[g][CNT_W-1:0]),
            .level (lvl_vec[g])
        );
    end

    irq_gather #(
        .NCH (NCH)
    ) u_gather (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl_vec),
        .pol   (pol_q),
        .clr   (clr_vec),
        .en    (en_q),
        .arm   (arm_q),
        .raw   (raw_vec),
        .pend  (pend_vec),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_level)     reg_rdata[NCH-1:0] = lvl_vec;
        else if (sel_gate) reg_rdata[NCH-1:0] = gate_q;
        else if (sel_pol)  reg_rdata[NCH-1:0] = pol_q;
        else if (sel_en)   reg_rdata[NCH-1:0] = en_q;
        else if (sel_raw)  reg_rdata[NCH-1:0] = raw_vec;
        else if (sel_pend) reg_rdata[NCH-1:0] = pend_vec;
        else if (sel_arm)  reg_rdata[NCH-1:0] = arm_q;
        else begin
            for (int i = 0; i < NCH; i++) begin
                if (time_hit[i]) reg_rdata = time_q[i];
            end
        end
    end
endmodule

// File: rtl/dbnc_irq_chk.sv
`timescale 1ns/1ps
module dbnc_irq_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic [NCH-1:0] gate,
    input logic [NCH-1:0] lvl,
    input logic [NCH-1:0] pol,
    input logic [NCH-1:0] en,
    input logic [NCH-1:0] arm,
    input logic [NCH-1:0] raw,
    input logic [NCH-1:0] clr,
    input logic           irq
);
    // R3: a channel whose gate was low leaves the edge with level 0
    a_r3_gated_level_low: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl & ~$past(gate)) == '0);

    // R4: the filtered level moves only on a tick or when a gate drops
    a_r4_level_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> ($past(tick) || !(&$past(gate))));

    // R7: a raw bit rises only after its level matched its polarity
    a_r7_raw_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~$past(raw) & ($past(lvl) ^ $past(pol))) == '0);

    // R8: a raw bit falls only after an acknowledge write to that bit
    a_r8_raw_fall_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (~raw & $past(raw) & ~$past(clr)) == '0);

    // R9: the request needs some channel both enabled and armed
    a_r9_irq_needs_en_arm: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((en & arm) != '0));
endmodule

bind dbnc_irq_bank dbnc_irq_chk #(.NCH(NCH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_ms),
    .gate  (gate_q),
    .lvl   (lvl_vec),
    .pol   (pol_q),
    .en    (en_q),
    .arm   (arm_q),
    .raw   (raw_vec),
    .clr   (clr_vec),
    .irq   (irq)
);

// File: tb/sim_dbnc_irq_bank.sv
`timescale 1ns/1ps
module sim_dbnc_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pins = '0;
    logic        tick = 1'b0;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dbnc_irq_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (we),
        .reg_addr  (addr),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .pin_in    (pins),
        .tick_ms   (tick),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        #1;
        chk(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pins = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 level", 8'h00, 32'h0);
        rd_chk("R1 polarity", 8'h14, 32'hFF);
        rd_chk("R1 raw", 8'h1C, 32'h0);
        rd_chk("R1 time7", 8'h5C, 32'h0);
        irq_chk("R1 irq", 1'b0);
    endtask

    task automatic t_regs();
        wr(8'h48, 32'hA5A5_0003);
        rd_chk("R2 time2 readback", 8'h48, 32'hA5A5_0003);
        wr(8'h40, 32'h0000_0003);
        rd_chk("R2 time0 readback", 8'h40, 32'h3);
        wr(8'h28, 32'h0000_0081);
        rd_chk("R2 arm readback", 8'h28, 32'h81);
        wr(8'h28, 32'h0);
    endtask

    task automatic t_gate();
        set_pins(8'hFF);
        pulse_ticks(3);
        rd_chk("R3 gated level", 8'h00, 32'h0);
        rd_chk("R3 gated raw", 8'h1C, 32'h0);
    endtask

    task automatic t_length();
        wr(8'h04, 32'h01);
        settle();
        pulse_ticks(2);
        rd_chk("R4 before N ticks", 8'h00, 32'h00);
        pulse_ticks(1);
        rd_chk("R4 after N ticks", 8'h00, 32'h01);
        rd_chk("R7 high level sets raw", 8'h1C, 32'h01);
    endtask

    task automatic t_zero();
        wr(8'h04, 32'h03);
        settle();
        pulse_ticks(1);
        rd_chk("R5 zero field one tick", 8'h00, 32'h03);
    endtask

    task automatic t_bounce();
        set_pins(8'hFB);
        wr(8'h04, 32'h07);
        settle();
        pulse_ticks(1);
        rd_chk("R6 start low", 8'h00, 32'h03);
        set_pins(8'hFF);
        pulse_ticks(2);
        set_pins(8'hFB);
        set_pins(8'hFF);
        pulse_ticks(2);
        rd_chk("R6 count restarted", 8'h00, 32'h03);
        pulse_ticks(1);
        rd_chk("R6 new level after fresh N", 8'h00, 32'h07);
        rd_chk("R2 upper time bits ignored", 8'h1C, 32'h07);
    endtask

    task automatic t_ack_pol();
        wr(8'h24, 32'h07);
        rd_chk("R8 active bits set again", 8'h1C, 32'h07);
        wr(8'h14, 32'hFE);
        wr(8'h24, 32'h01);
        rd_chk("R8 acked bit clears", 8'h1C, 32'h06);
        set_pins(8'hFE);
        pulse_ticks(2);
        rd_chk("R4 ch0 still high", 8'h00, 32'h07);
        rd_chk("R7 no match yet", 8'h1C, 32'h06);
        pulse_ticks(1);
        rd_chk("R7 low level sets raw", 8'h1C, 32'h07);
        wr(8'h24, 32'h00);
        rd_chk("R8 zero write no effect", 8'h1C, 32'h07);
    endtask

    task automatic t_mask();
        wr(8'h18, 32'h01);
        rd_chk("R9 enable only pend", 8'h20, 32'h0);
        irq_chk("R9 enable only irq", 1'b0);
        wr(8'h28, 32'h01);
        rd_chk("R9 enable and arm pend", 8'h20, 32'h01);
        irq_chk("R9 enable and arm irq", 1'b1);
        wr(8'h18, 32'h00);
        irq_chk("R9 arm only irq", 1'b0);
        wr(8'h18, 32'h06);
        wr(8'h28, 32'h02);
        rd_chk("R9 ch1 pend", 8'h20, 32'h02);
        irq_chk("R9 ch1 irq", 1'b1);
    endtask

    task automatic t_readonly();
        wr(8'h00, 32'h0);
        wr(8'h1C, 32'h0);
        wr(8'h20, 32'h0);
        rd_chk("R10 level write ignored", 8'h00, 32'h06);
        rd_chk("R10 raw write ignored", 8'h1C, 32'h07);
        rd_chk("R10 pend write ignored", 8'h20, 32'h02);
        rd_chk("R10 ack reads zero", 8'h24, 32'h0);
        rd_chk("R10 unmapped reads zero", 8'h30, 32'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_gate();
        t_length();
        t_zero();
        t_bounce();
        t_ack_pol();
        t_mask();
        t_readonly();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule